// File: doc/BRIEF.md
# VGA Indexed Register File Emulator

This block stands in for the byte-wide I/O register set of a standard VGA adapter at addresses 0x3C0 through 0x3DA. It holds five register groups behind their index/data port pairs: attribute, sequencer, graphics, CRT and the DAC colour table. It also holds a few single registers: miscellaneous output, pixel mask and input status. Firmware that programs a display controller can run its port accesses against this block without the adapter itself. Nothing here generates pixels or video timing.

A host issues single-cycle accesses on one shared port address bus. A read strobe returns a byte on `io_rdata` at the next clock edge. A write strobe stores `io_wdata[7:0]`, or with `io_wide` set it splits a 16-bit value into two byte writes on consecutive cycles. Some accesses have side effects: the attribute port alternates between index and data roles, and reading the status port clears that alternation and changes the status value. DAC pointers advance on each access. CRT accesses are gated by a bit of the miscellaneous register.

Top module: `vga_regfile_emu`

## Requirements
- R1: After reset, every index register, both DAC pointers, the attribute toggle, the status, miscellaneous and pixel-mask registers and `io_rdata` are 0x00.
- R2: Port 0x3C0 reads or writes the attribute index while the attribute toggle is clear, and the attribute register selected by that index while it is set. Every read or write of 0x3C0 inverts the toggle.
- R3: A read of 0x3DA returns the status value, clears the attribute toggle and afterwards XORs the status value with 0x09.
- R4: A read of 0x3C1 returns the attribute register selected by the attribute index, or 0xFF when the index is 21 or more. Attribute data writes with such an index are discarded.
- R5: A write to 0x3C2 stores the miscellaneous value, which reads back at 0x3CC. A read of 0x3C2 returns 0xFF.
- R6: 0x3C4/0x3C5 (5 registers) and 0x3CE/0x3CF (9 registers) are index/data pairs. Each index port reads back its index. A data access with an index at or above the group size is discarded on write and returns 0xFF on read.
- R7: A write of value v to 0x3C7 sets the DAC read pointer to 3*v, and a write to 0x3C8 sets the write pointer to 3*v. Reads of 0x3C7 and 0x3C8 return the low 8 bits of the read and write pointers.
- R8: A write to 0x3C9 stores into the 768-byte colour table at the write pointer, and a read returns the byte at the read pointer. Each access then increments its pointer. At a pointer of 768 or more the access is discarded, the pointer holds, and a read returns 0xFF.
- R9: When miscellaneous bit 0 is clear, writes to 0x3D4/0x3D5 are discarded and reads of them return 0xFF. When it is set they form an index/data pair over 25 CRT registers with the same range rule as R6.
- R10: 0x3C6 is a plain read/write pixel-mask register. Reads of any port without a read function (for example 0x3C3, 0x3D0, or any address outside the range) return 0xFF, and writes to ports without a write function change nothing.
- R11: A write with `io_wide` set writes `io_wdata[7:0]` to the addressed port in that cycle and `io_wdata[15:8]` to the address plus one in the next cycle. Host strobes during that second cycle are ignored.
- R12: `io_rdata` changes only on an accepted read. A cycle with both strobes set is treated as a write only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released inside |
| io_addr | input | 16 | Port address of the access |
| io_wr | input | 1 | Write strobe |
| io_wide | input | 1 | With io_wr, write 16 bits as two byte writes |
| io_wdata | input | 16 | Write data; low byte used for byte writes |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data, updated at the clock edge that accepts a read |

## Verification
Every cycle, assertions check the local effects of side-effecting accesses. They cover the attribute toggle inverting on 0x3C0 accesses and clearing on a status read, and the status value flipping by 0x09. They also check the DAC pointer stepping and bounds, the CRT index holding while the gate bit is clear, the high-byte write issued after a wide write, and read data holding between reads. The bench scenarios are needed to show the results of access sequences. These include data written through the toggled attribute port and read back at 0x3C1, the DAC pointer reload, the step past the 768th entry, the out-of-range indices returning 0xFF, and a write during the second half of a wide write being dropped.

// File: rtl/vga_emu_pkg.sv
`timescale 1ns/1ps
package vga_emu_pkg;
  typedef logic [7:0] byte_t;

  localparam logic [15:0] PORT_ATTR_IX   = 16'h03C0;
  localparam logic [15:0] PORT_ATTR_RD   = 16'h03C1;
  localparam logic [15:0] PORT_MISC_WR   = 16'h03C2;
  localparam logic [15:0] PORT_SEQ_IX    = 16'h03C4;
  localparam logic [15:0] PORT_SEQ_DT    = 16'h03C5;
  localparam logic [15:0] PORT_PEL_MASK  = 16'h03C6;
  localparam logic [15:0] PORT_DAC_RPTR  = 16'h03C7;
  localparam logic [15:0] PORT_DAC_WPTR  = 16'h03C8;
  localparam logic [15:0] PORT_DAC_DATA  = 16'h03C9;
  localparam logic [15:0] PORT_MISC_RD   = 16'h03CC;
  localparam logic [15:0] PORT_GFX_IX    = 16'h03CE;
  localparam logic [15:0] PORT_GFX_DT    = 16'h03CF;
  localparam logic [15:0] PORT_CRT_IX    = 16'h03D4;
  localparam logic [15:0] PORT_CRT_DT    = 16'h03D5;
  localparam logic [15:0] PORT_STATUS    = 16'h03DA;

  localparam byte_t NO_DATA     = 8'hFF;
  localparam byte_t STATUS_FLIP = 8'h09;

  localparam int BANK_ATTR = 0;
  localparam int BANK_SEQ  = 1;
  localparam int BANK_GFX  = 2;
  localparam int BANK_CRT  = 3;
  localparam int BANK_CNT  = 4;
endpackage

// File: rtl/vga_word_split.sv
`timescale 1ns/1ps
module vga_word_split #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_wr,
  input  logic          in_wide,
  input  logic [AW-1:0] in_addr,
  input  logic [15:0]   in_data,
  output logic          out_wr,
  output logic [AW-1:0] out_addr,
  output logic [7:0]    out_data,
  output logic          busy
);
  logic          pend_q, pend_d;
  logic [AW-1:0] hold_addr_q;
  logic [7:0]    hold_data_q;

  always_comb begin
    pend_d = in_wr & in_wide & ~pend_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_addr_q <= '0;
      hold_data_q <= '0;
    end else if (pend_d) begin
      hold_addr_q <= in_addr + AW'(1);
      hold_data_q <= in_data[15:8];
    end
  end

  always_comb begin
    busy     = pend_q;
    out_wr   = pend_q | in_wr;
    out_addr = pend_q ? hold_addr_q : in_addr;
    out_data = pend_q ? hold_data_q : in_data[7:0];
  end

  AST_SPLIT_HIGH_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wr && in_wide && !pend_q) |=> (out_wr && out_addr == $past(in_addr) + AW'(1) && out_data == $past(in_data[15:8]))) else $error("split"); // R11
  AST_SPLIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |=> !pend_q) else $error("split chain"); // R11
endmodule

// File: rtl/vga_index_bank.sv
`timescale 1ns/1ps
module vga_index_bank
  import vga_emu_pkg::*;
#(
  parameter int SIZE = 5
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  idx_we,
  input  logic  dat_we,
  input  byte_t wdata,
  output byte_t idx,
  output byte_t dat
);
  localparam logic [8:0] LIMIT = 9'(SIZE);

  byte_t idx_q;
  byte_t regs_q [SIZE];
  logic  in_range;

  always_comb in_range = ({1'b0, idx_q} < LIMIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_we) idx_q <= wdata;
  end

  for (genvar g = 0; g < SIZE; g++) begin : g_reg
    logic en;
    always_comb en = dat_we & in_range & (idx_q == 8'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  regs_q[g] <= '0;
      else if (en) regs_q[g] <= wdata;
    end
  end

  always_comb begin
    dat = NO_DATA;
    for (int i = 0; i < SIZE; i++) begin
      if (idx_q == 8'(i)) dat = regs_q[i];
    end
    idx = idx_q;
  end

  AST_BANK_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_we && in_range && !idx_we) |=> (dat == $past(wdata))) else $error("bank store"); // R6
  AST_BANK_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_range |-> (dat == NO_DATA)) else $error("bank range"); // R6
endmodule

// File: rtl/vga_dac_table.sv
`timescale 1ns/1ps
module vga_dac_table
  import vga_emu_pkg::*;
#(
  parameter int PAL_SIZE = 768
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  rptr_we,
  input  logic  wptr_we,
  input  logic  data_wr,
  input  logic  data_rd,
  input  byte_t wdata,
  output byte_t rptr_lo,
  output byte_t wptr_lo,
  output byte_t rd_byte
);
  localparam int PW = $clog2(PAL_SIZE + 1);
  localparam logic [PW-1:0] LIMIT = PW'(PAL_SIZE);

  logic [PW-1:0] rptr_q, rptr_d, wptr_q, wptr_d, load_val;
  byte_t         tbl [PAL_SIZE];
  logic          r_ok, w_ok;

  always_comb begin
    load_val = PW'(wdata) + PW'({wdata, 1'b0});
    r_ok     = rptr_q < LIMIT;
    w_ok     = wptr_q < LIMIT;
    rptr_d   = rptr_q;
    wptr_d   = wptr_q;
    if (rptr_we)              rptr_d = load_val;
    else if (data_rd && r_ok) rptr_d = rptr_q + PW'(1);
    if (wptr_we)              wptr_d = load_val;
    else if (data_wr && w_ok) wptr_d = wptr_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
      wptr_q <= '0;
    end else begin
      rptr_q <= rptr_d;
      wptr_q <= wptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (data_wr && w_ok) tbl[wptr_q] <= wdata;
  end

  always_comb begin
    rptr_lo = rptr_q[7:0];
    wptr_lo = wptr_q[7:0];
    rd_byte = r_ok ? tbl[rptr_q] : NO_DATA;
  end

  AST_DAC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (rptr_q <= LIMIT) && (wptr_q <= LIMIT)) else $error("dac bound"); // R8
  AST_DAC_WSTEP: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !wptr_we && w_ok) |=> (wptr_q == $past(wptr_q) + PW'(1))) else $error("dac wstep"); // R8
  AST_DAC_RHOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !rptr_we && !r_ok) |=> $stable(rptr_q)) else $error("dac rhold"); // R8
  AST_DAC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wptr_we |=> (wptr_q == PW'($past(wdata)) * PW'(3))) else $error("dac load"); // R7
endmodule

// File: rtl/vga_regfile_emu.sv
`timescale 1ns/1ps
module vga_regfile_emu
  import vga_emu_pkg::*;
#(
  parameter int ATTR_N = 21,
  parameter int SEQ_N  = 5,
  parameter int GFX_N  = 9,
  parameter int CRT_N  = 25,
  parameter int PAL_N  = 768
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] io_addr,
  input  logic        io_wr,
  input  logic        io_wide,
  input  logic [15:0] io_wdata,
  input  logic        io_rd,
  output logic [7:0]  io_rdata
);
  localparam int BANK_SZ [BANK_CNT] = '{ATTR_N, SEQ_N, GFX_N, CRT_N};

  logic [1:0] rst_sync_q;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  always_comb rst_i = rst_sync_q[1];

  logic        bw, busy, rd_go;
  logic [15:0] baddr;
  byte_t       bdata;

  vga_word_split #(.AW(16)) split_i (
    .clk(clk), .rst_n(rst_i), .in_wr(io_wr), .in_wide(io_wide),
    .in_addr(io_addr), .in_data(io_wdata),
    .out_wr(bw), .out_addr(baddr), .out_data(bdata), .busy(busy)
  );

  always_comb rd_go = io_rd & ~io_wr & ~busy;

  logic tog_q, tog_d;
  byte_t misc_q, misc_d, mask_q, mask_d, stat_q, stat_d, rdata_q, rdata_d, rd_mux;
  logic w_attr, r_attr, r_stat;
  logic [BANK_CNT-1:0] b_idx_we, b_dat_we;
  byte_t b_idx [BANK_CNT];
  byte_t b_dat [BANK_CNT];
  logic dac_rp_we, dac_wp_we, dac_wr, dac_rd;
  byte_t dac_rp, dac_wp, dac_byte;

  always_comb begin
    w_attr = bw && (baddr == PORT_ATTR_IX);
    r_attr = rd_go && (io_addr == PORT_ATTR_IX);
    r_stat = rd_go && (io_addr == PORT_STATUS);

    b_idx_we[BANK_ATTR] = w_attr & ~tog_q;
    b_dat_we[BANK_ATTR] = w_attr &  tog_q;
    b_idx_we[BANK_SEQ]  = bw && (baddr == PORT_SEQ_IX);
    b_dat_we[BANK_SEQ]  = bw && (baddr == PORT_SEQ_DT);
    b_idx_we[BANK_GFX]  = bw && (baddr == PORT_GFX_IX);
    b_dat_we[BANK_GFX]  = bw && (baddr == PORT_GFX_DT);
    b_idx_we[BANK_CRT]  = bw && (baddr == PORT_CRT_IX) && misc_q[0];
    b_dat_we[BANK_CRT]  = bw && (baddr == PORT_CRT_DT) && misc_q[0];

    dac_rp_we = bw && (baddr == PORT_DAC_RPTR);
    dac_wp_we = bw && (baddr == PORT_DAC_WPTR);
    dac_wr    = bw && (baddr == PORT_DAC_DATA);
    dac_rd    = rd_go && (io_addr == PORT_DAC_DATA);
  end

  for (genvar g = 0; g < BANK_CNT; g++) begin : g_bank
    vga_index_bank #(.SIZE(BANK_SZ[g])) bank_i (
      .clk(clk), .rst_n(rst_i), .idx_we(b_idx_we[g]), .dat_we(b_dat_we[g]),
      .wdata(bdata), .idx(b_idx[g]), .dat(b_dat[g])
    );
  end

  vga_dac_table #(.PAL_SIZE(PAL_N)) dac_i (
    .clk(clk), .rst_n(rst_i), .rptr_we(dac_rp_we), .wptr_we(dac_wp_we),
    .data_wr(dac_wr), .data_rd(dac_rd), .wdata(bdata),
    .rptr_lo(dac_rp), .wptr_lo(dac_wp), .rd_byte(dac_byte)
  );

  always_comb begin
    unique case (io_addr)
      PORT_ATTR_IX:  rd_mux = tog_q ? b_dat[BANK_ATTR] : b_idx[BANK_ATTR];
      PORT_ATTR_RD:  rd_mux = b_dat[BANK_ATTR];
      PORT_SEQ_IX:   rd_mux = b_idx[BANK_SEQ];
      PORT_SEQ_DT:   rd_mux = b_dat[BANK_SEQ];
      PORT_PEL_MASK: rd_mux = mask_q;
      PORT_DAC_RPTR: rd_mux = dac_rp;
      PORT_DAC_WPTR: rd_mux = dac_wp;
      PORT_DAC_DATA: rd_mux = dac_byte;
      PORT_MISC_RD:  rd_mux = misc_q;
      PORT_GFX_IX:   rd_mux = b_idx[BANK_GFX];
      PORT_GFX_DT:   rd_mux = b_dat[BANK_GFX];
      PORT_CRT_IX:   rd_mux = misc_q[0] ? b_idx[BANK_CRT] : NO_DATA;
      PORT_CRT_DT:   rd_mux = misc_q[0] ? b_dat[BANK_CRT] : NO_DATA;
      PORT_STATUS:   rd_mux = stat_q;
      default:       rd_mux = NO_DATA;
    endcase
  end

  always_comb begin
    tog_d   = tog_q;
    if (r_stat)                tog_d = 1'b0;
    else if (w_attr || r_attr) tog_d = ~tog_q;
    misc_d  = (bw && baddr == PORT_MISC_WR)  ? bdata : misc_q;
    mask_d  = (bw && baddr == PORT_PEL_MASK) ? bdata : mask_q;
    stat_d  = r_stat ? (stat_q ^ STATUS_FLIP) : stat_q;
    rdata_d = rd_go ? rd_mux : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      tog_q   <= 1'b0;
      misc_q  <= '0;
      mask_q  <= '0;
      stat_q  <= '0;
      rdata_q <= '0;
    end else begin
      tog_q   <= tog_d;
      misc_q  <= misc_d;
      mask_q  <= mask_d;
      stat_q  <= stat_d;
      rdata_q <= rdata_d;
    end
  end

  always_comb io_rdata = rdata_q;

  AST_ATTR_TOGGLE: assert property (@(posedge clk) disable iff (!rst_i)
    (w_attr || r_attr) |=> (tog_q != $past(tog_q))) else $error("toggle"); // R2
  AST_STATUS_CLEARS: assert property (@(posedge clk) disable iff (!rst_i)
    r_stat |=> !tog_q) else $error("status clear"); // R3
  AST_STATUS_FLIP: assert property (@(posedge clk) disable iff (!rst_i)
    r_stat |=> (stat_q == ($past(stat_q) ^ STATUS_FLIP))) else $error("status flip"); // R3
  AST_CRT_GATED: assert property (@(posedge clk) disable iff (!rst_i)
    (bw && baddr == PORT_CRT_IX && !misc_q[0]) |=> $stable(b_idx[BANK_CRT])) else $error("crt gate"); // R9
  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_i)
    !rd_go |=> $stable(io_rdata)) else $error("read hold"); // R12
  AST_MISC_STORE: assert property (@(posedge clk) disable iff (!rst_i)
    (bw && baddr == PORT_MISC_WR) |=> (misc_q == $past(bdata))) else $error("misc"); // R5
endmodule

// File: tb/vga_regfile_emu_tb_top.sv
`timescale 1ns/1ps
module vga_regfile_emu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_wide = 1'b0;
  logic [15:0] io_wdata = '0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_rdata;
  logic        tb_expect = 1'b0;

  int checks = 0;
  int failures = 0;
  logic [7:0] st_m = 8'h00;
  bit done = 1'b0;

  typedef struct { logic [7:0] v; string tag; } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  vga_regfile_emu dut_i (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_wide(io_wide), .io_wdata(io_wdata), .io_rd(io_rd), .io_rdata(io_rdata)
  );

  // monitor: compares each accepted read against the scoreboard
  always begin
    @(posedge clk);
    if (io_rd && tb_expect) begin
      #1;
      if (sb_q.size() == 0) begin
        failures++;
        $display("FAIL scoreboard empty actual=%02h expected=none", io_rdata);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        checks++;
        if (io_rdata !== e.v) begin
          failures++;
          $display("FAIL %s actual=%02h expected=%02h", e.tag, io_rdata, e.v);
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr_b(input logic [15:0] a, input logic [7:0] d);
    io_addr = a; io_wdata = {8'h00, d}; io_wr = 1'b1; io_wide = 1'b0;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic wr_w(input logic [15:0] a, input logic [15:0] d);
    io_addr = a; io_wdata = d; io_wr = 1'b1; io_wide = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_wide = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_b(input logic [15:0] a, input logic [7:0] exp, input string tag);
    exp_t e;
    e.v = exp; e.tag = tag;
    sb_q.push_back(e);
    io_addr = a; io_rd = 1'b1; tb_expect = 1'b1;
    @(negedge clk);
    io_rd = 1'b0; tb_expect = 1'b0;
  endtask

  task automatic rd_stat();
    rd_b(16'h03DA, st_m, "R3");
    st_m = st_m ^ 8'h09;
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1", io_rdata, 8'h00);
    rd_b(16'h03C4, 8'h00, "R1");
    rd_b(16'h03C8, 8'h00, "R1");
    rd_b(16'h03CC, 8'h00, "R1");
    rd_b(16'h03C0, 8'h00, "R1");  // toggle clear: index, toggle now set
    rd_stat();                     // clears toggle

    // R2 / R4 attribute port
    wr_b(16'h03C0, 8'h03);
    wr_b(16'h03C0, 8'h5A);
    rd_b(16'h03C1, 8'h5A, "R4");
    rd_b(16'h03C0, 8'h03, "R2");
    rd_b(16'h03C0, 8'h5A, "R2");
    // R3 status read clears toggle
    wr_b(16'h03C0, 8'h07);
    rd_stat();
    wr_b(16'h03C0, 8'h03);
    rd_b(16'h03C1, 8'h5A, "R3");
    rd_stat();
    wr_b(16'h03C0, 8'h15);
    wr_b(16'h03C0, 8'h77);
    rd_b(16'h03C1, 8'hFF, "R4");
    rd_stat();

    // R9 CRT gating and R5 misc
    wr_b(16'h03D4, 8'h02);
    rd_b(16'h03D4, 8'hFF, "R9");
    rd_b(16'h03D5, 8'hFF, "R9");
    wr_b(16'h03C2, 8'h01);
    rd_b(16'h03CC, 8'h01, "R5");
    rd_b(16'h03C2, 8'hFF, "R5");
    rd_b(16'h03D4, 8'h00, "R9");
    wr_b(16'h03D4, 8'h18);
    wr_b(16'h03D5, 8'h66);
    rd_b(16'h03D5, 8'h66, "R9");
    rd_b(16'h03D4, 8'h18, "R9");
    wr_b(16'h03C2, 8'h00);
    rd_b(16'h03D5, 8'hFF, "R9");
    wr_b(16'h03D5, 8'h77);
    wr_b(16'h03C2, 8'h01);
    rd_b(16'h03D5, 8'h66, "R9");
    wr_b(16'h03D4, 8'h19);
    wr_b(16'h03D5, 8'h12);
    rd_b(16'h03D5, 8'hFF, "R9");

    // R11 wide write, R6 sequencer/graphics
    wr_w(16'h03C4, 16'h9902);
    rd_b(16'h03C5, 8'h99, "R11");
    rd_b(16'h03C4, 8'h02, "R11");
    wr_b(16'h03C4, 8'h05);
    wr_b(16'h03C5, 8'h12);
    rd_b(16'h03C5, 8'hFF, "R6");
    rd_b(16'h03C4, 8'h05, "R6");
    wr_b(16'h03CE, 8'h08);
    wr_b(16'h03CF, 8'h44);
    rd_b(16'h03CF, 8'h44, "R6");
    wr_b(16'h03CE, 8'h09);
    rd_b(16'h03CF, 8'hFF, "R6");
    rd_b(16'h03CE, 8'h09, "R6");
    // R11 strobe in the second half is dropped
    io_addr = 16'h03CE; io_wdata = 16'h5508; io_wr = 1'b1; io_wide = 1'b1;
    @(negedge clk);
    io_wide = 1'b0; io_addr = 16'h03C6; io_wdata = 16'h0033; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
    rd_b(16'h03CF, 8'h55, "R11");
    rd_b(16'h03C6, 8'h00, "R11");

    // R7 / R8 DAC
    wr_b(16'h03C8, 8'h02);
    wr_b(16'h03C9, 8'h11);
    wr_b(16'h03C9, 8'h22);
    rd_b(16'h03C8, 8'h08, "R7");
    wr_b(16'h03C7, 8'h02);
    rd_b(16'h03C7, 8'h06, "R7");
    rd_b(16'h03C9, 8'h11, "R8");
    rd_b(16'h03C9, 8'h22, "R8");
    rd_b(16'h03C7, 8'h08, "R8");
    wr_b(16'h03C8, 8'hFF);
    rd_b(16'h03C8, 8'hFD, "R7");
    for (int i = 1; i <= 4; i++) wr_b(16'h03C9, 8'hA0 + 8'(i));
    rd_b(16'h03C8, 8'h00, "R8");
    wr_b(16'h03C7, 8'hFF);
    rd_b(16'h03C9, 8'hA1, "R8");
    rd_b(16'h03C9, 8'hA2, "R8");
    rd_b(16'h03C9, 8'hA3, "R8");
    rd_b(16'h03C9, 8'hFF, "R8");
    rd_b(16'h03C7, 8'h00, "R8");

    // R10 unhandled ports and pixel mask
    wr_b(16'h03C3, 8'h12);
    rd_b(16'h03C3, 8'hFF, "R10");
    rd_b(16'h03D0, 8'hFF, "R10");
    rd_b(16'h0061, 8'hFF, "R10");
    wr_b(16'h03C6, 8'h3C);
    rd_b(16'h03C6, 8'h3C, "R10");

    // R12 read data hold, write wins over read
    rd_b(16'h03CC, 8'h01, "R12");
    repeat (3) @(negedge clk);
    chk("R12", io_rdata, 8'h01);
    io_addr = 16'h03C6; io_wdata = 16'h0081; io_wr = 1'b1; io_rd = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0;
    chk("R12", io_rdata, 8'h01);
    rd_b(16'h03C6, 8'h81, "R12");
    rd_stat();

    repeat (3) @(negedge clk);
    if (sb_q.size() != 0) begin
      failures++;
      $display("FAIL scoreboard leftover actual=%0d expected=0", sb_q.size());
    end
    done = 1'b1;
    report();
    $finish;
  end
endmodule